// File: doc/BRIEF.md
# Interrupt and Reset Response Controller

This block sits beside the sequencer of an 8-bit processor core and owns everything that happens between "an exception is wanted" and "the core resumes fetching somewhere else". It keeps the two interrupt-enable flip-flops, the maskable-interrupt mode (0, 1 or 2) and the 8-bit vector page register. It drives the acknowledge strobes: opcode-fetch (`m1_n`), I/O request (`iorq_n`) and refresh (`rfsh_n`). It samples the byte that the interrupting device places on the data bus. At the end of each response it hands the core a target address, a push request with the two stack slots, the return address and a clock count.

The core reports instruction boundaries and drives single-cycle commands for enable, disable, mode select, vector-page load and return-from-NMI. A non-maskable request is edge-triggered and held until the next boundary. A maskable request is a level, taken only at a boundary while the first enable flip-flop is set. Clock 0 of a response is the first clock after the edge that accepts it. The response descriptor is valid for exactly the one clock in which `resp_valid` is high, which is the last clock of the response.

Top module: `irq_resp_ctrl`

## Requirements
- R1: While `rst_n` is low, both enables, the mode and the vector page are zero. After release, `resp_valid` is high in clock 2, which is the third clock with `rst_n` high. In that clock `resp_kind`=0 (reset), `resp_target`=0x0000, `resp_push`=0 and `resp_cycles`=3.
- R2: On accepting an NMI, the second enable takes the old value of the first enable and the first enable is cleared. The response has `resp_kind`=1, `resp_target`=0x0066, `resp_push`=1 and `resp_cycles`=11, and `resp_valid` and `halt_release` are high in clock 10. `m1_n` is low in clocks 0 to 3 only, and `iorq_n` stays high.
- R3: A rising edge on `nmi_req` is remembered until a boundary. When an NMI is pending and `int_req` is also asserted at the same boundary, the NMI is taken.
- R4: A maskable request is accepted only when `insn_boundary`=1, `int_req`=1 and the first enable is 1. Acceptance clears both enables, and the response has `resp_kind`=2.
- R5: The maskable acknowledge waits two settling clocks (0 and 1). `m1_n` is low in clocks 2 to 5. `iorq_n` is low in clock 4 only, and `ack_data` is sampled in that clock. `rfsh_n` is low in clock 5 only.
- R6: In mode 1 the target is 0x0038 whatever the bus byte is, with push=1 and cycles=13, and `resp_valid` is high in clock 12.
- R7: In mode 2 `tbl_rd` is high in clock 6 only, with `tbl_addr` = {vector page, bus byte}. The target is the 16-bit `tbl_data` returned in that clock, with push=1 and cycles=13, and `resp_valid` is high in clock 12.
- R8: In mode 0 a bus byte of the form 11yyy111 gives target yyy×8, with push=1 and cycles=13, and `resp_valid` is high in clock 12.
- R9: In mode 0 any other bus byte ends the response in clock 5 with target = return address, push=0 and cycles=6.
- R10: `ret_addr` is `pc_in` captured at acceptance. `push_addr_hi` is the captured `sp_in` minus 1 and `push_addr_lo` is the captured `sp_in` minus 2.
- R11: When idle, `cmd_ei` sets both enables and `cmd_di` clears both. `cmd_im` loads the mode from `im_sel` (0, 1 or 2), and code 3 leaves the mode unchanged. `cmd_ld_i` loads the vector page from `i_data`.
- R12: When idle, `cmd_retn` copies the second enable into the first.
- R13: An `cmd_ei` in the same clock as an accepted interrupt has no effect, so both enables are zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_boundary | input | 1 | Core is between instructions |
| nmi_req | input | 1 | Non-maskable request, rising edge taken |
| int_req | input | 1 | Maskable request, level |
| ack_data | input | 8 | Data bus byte from the interrupting device |
| pc_in | input | 16 | Address of the next instruction |
| sp_in | input | 16 | Current stack pointer |
| cmd_ei | input | 1 | Enable maskable interrupts |
| cmd_di | input | 1 | Disable maskable interrupts |
| cmd_retn | input | 1 | Return from NMI: restore first enable |
| cmd_im | input | 1 | Load interrupt mode |
| im_sel | input | 2 | Mode code for `cmd_im` |
| cmd_ld_i | input | 1 | Load vector page |
| i_data | input | 8 | Vector page value for `cmd_ld_i` |
| tbl_data | input | 16 | Word read from the vector table |
| m1_n | output | 1 | Opcode-fetch/acknowledge strobe, active low |
| iorq_n | output | 1 | I/O request strobe, active low |
| rfsh_n | output | 1 | Refresh strobe, active low |
| tbl_rd | output | 1 | Vector-table read request |
| tbl_addr | output | 16 | Vector-table address |
| resp_valid | output | 1 | Response descriptor valid (last clock) |
| resp_kind | output | 2 | 0 reset, 1 NMI, 2 maskable |
| resp_target | output | 16 | Address to continue from |
| resp_push | output | 1 | Core must push the return address |
| resp_cycles | output | 4 | Clock count of the response |
| ret_addr | output | 16 | Return address to push |
| push_addr_hi | output | 16 | Stack slot for the high byte |
| push_addr_lo | output | 16 | Stack slot for the low byte |
| halt_release | output | 1 | Leave the halt state |
| iff1 | output | 1 | First interrupt enable |
| iff2 | output | 1 | Second interrupt enable |
| im_mode | output | 2 | Current interrupt mode |
| i_reg | output | 8 | Vector page register |

## Verification
The two functions that meet in one clock are NMI acceptance and maskable acceptance. Both look at the same instruction boundary, and the flag commands change the enables in that same clock. The bench latches an NMI edge and then raises `int_req` with the first enable set at the next boundary, and judges the result by `resp_kind`, `resp_target` and the NMI copy rule on the enables. It also asserts `cmd_ei` in the very clock a maskable request is accepted and requires both enables to read zero when the response completes.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    SQ_RST  = 2'd0,
    SQ_IDLE = 2'd1,
    SQ_NMI  = 2'd2,
    SQ_INT  = 2'd3
  } seq_state_t;

  localparam logic [1:0] KIND_RESET = 2'd0;
  localparam logic [1:0] KIND_NMI   = 2'd1;
  localparam logic [1:0] KIND_INT   = 2'd2;

  localparam logic [1:0] MODE_BUS_OP = 2'd0;
  localparam logic [1:0] MODE_FIXED  = 2'd1;
  localparam logic [1:0] MODE_TABLE  = 2'd2;

  // single-byte restart opcode: 11yyy111
  function automatic logic is_restart(input byte_t b);
    return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
  endfunction

  function automatic addr_t restart_target(input byte_t b);
    return addr_t'({b[5:3], 3'b000});
  endfunction

  function automatic addr_t table_ptr(input byte_t page, input byte_t b);
    return {page, b};
  endfunction

  function automatic addr_t stack_slot(input addr_t sp, input int unsigned depth);
    return sp - addr_t'(depth);
  endfunction

endpackage

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_resp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle,
  input  logic       take_nmi,
  input  logic       take_int,
  input  logic       cmd_ei,
  input  logic       cmd_di,
  input  logic       cmd_retn,
  input  logic       cmd_im,
  input  logic [1:0] im_sel,
  input  logic       cmd_ld_i,
  input  byte_t      i_data,
  output logic       iff1,
  output logic       iff2,
  output logic [1:0] im_mode,
  output byte_t      i_reg
);

  logic im_code_ok;
  assign im_code_ok = (im_sel != 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (take_nmi) begin
      iff2 <= iff1;
      iff1 <= 1'b0;
    end else if (take_int) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (idle) begin
      if (cmd_di) begin
        iff1 <= 1'b0;
        iff2 <= 1'b0;
      end else if (cmd_ei) begin
        iff1 <= 1'b1;
        iff2 <= 1'b1;
      end else if (cmd_retn) begin
        iff1 <= iff2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      im_mode <= MODE_BUS_OP;
      i_reg   <= '0;
    end else if (idle) begin
      if (cmd_im && im_code_ok) im_mode <= im_sel;
      if (cmd_ld_i)             i_reg   <= i_data;
    end
  end

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_resp_pkg::*;
#(
  parameter int SETTLE_CLKS = 2,
  parameter int NMI_M1_CLKS = 4,
  parameter int RST_CLKS    = 3,
  parameter int NMI_CLKS    = 11,
  parameter int INT_CLKS    = 13,
  parameter int CNT_W       = 4
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_boundary,
  input  logic       nmi_req,
  input  logic       int_req,
  input  logic       iff1,
  input  logic [1:0] im_mode,
  input  logic       short_end,
  output logic       idle,
  output logic       take_nmi,
  output logic       take_int,
  output logic       in_rst,
  output logic       in_nmi,
  output logic       in_int,
  output logic       sample_en,
  output logic       tbl_rd,
  output logic       m1_n,
  output logic       iorq_n,
  output logic       rfsh_n,
  output logic       resp_valid
);

  localparam int ACK_CLKS = SETTLE_CLKS + 4;
  localparam logic [CNT_W-1:0] C_M1_BEG  = CNT_W'(SETTLE_CLKS);
  localparam logic [CNT_W-1:0] C_IORQ    = CNT_W'(SETTLE_CLKS + 2);
  localparam logic [CNT_W-1:0] C_ACK_END = CNT_W'(ACK_CLKS - 1);
  localparam logic [CNT_W-1:0] C_TBL     = CNT_W'(ACK_CLKS);
  localparam logic [CNT_W-1:0] C_INT_END = CNT_W'(INT_CLKS - 1);
  localparam logic [CNT_W-1:0] C_NMI_END = CNT_W'(NMI_CLKS - 1);
  localparam logic [CNT_W-1:0] C_RST_END = CNT_W'(RST_CLKS - 1);
  localparam logic [CNT_W-1:0] C_NMI_M1  = CNT_W'(NMI_M1_CLKS);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             nmi_q;
  logic             nmi_pend;
  logic             nmi_edge;
  logic             last_clk;

  assign idle   = (state == SQ_IDLE);
  assign in_rst = (state == SQ_RST);
  assign in_nmi = (state == SQ_NMI);
  assign in_int = (state == SQ_INT);

  assign nmi_edge = nmi_req & ~nmi_q;
  assign take_nmi = idle & insn_boundary & nmi_pend;
  assign take_int = idle & insn_boundary & ~nmi_pend & int_req & iff1;

  always_comb begin
    last_clk = 1'b0;
    case (state)
      SQ_RST:  last_clk = (cnt == C_RST_END);
      SQ_NMI:  last_clk = (cnt == C_NMI_END);
      SQ_INT:  last_clk = (cnt == C_INT_END) || ((cnt == C_ACK_END) && short_end);
      default: last_clk = 1'b0;
    endcase
  end

  assign resp_valid = last_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_RST;
      cnt      <= '0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_req;
      nmi_pend <= (nmi_pend & ~take_nmi) | nmi_edge;
      if (idle) begin
        cnt <= '0;
        if (take_nmi)      state <= SQ_NMI;
        else if (take_int) state <= SQ_INT;
      end else if (last_clk) begin
        state <= SQ_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign m1_n      = ~((in_int && (cnt >= C_M1_BEG) && (cnt <= C_ACK_END)) ||
                       (in_nmi && (cnt < C_NMI_M1)));
  assign iorq_n    = ~(in_int && (cnt == C_IORQ));
  assign rfsh_n    = ~(in_int && (cnt == C_ACK_END));
  assign sample_en = in_int && (cnt == C_IORQ);
  assign tbl_rd    = in_int && (cnt == C_TBL) && (im_mode == MODE_TABLE);

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_resp_pkg::*;
#(
  parameter int    SETTLE_CLKS = 2,
  parameter int    RST_CLKS    = 3,
  parameter int    NMI_CLKS    = 11,
  parameter int    INT_CLKS    = 13,
  parameter int    CYC_W       = 4,
  parameter addr_t NMI_VECTOR  = 16'h0066,
  parameter addr_t FIX_VECTOR  = 16'h0038
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             sample_en,
  input  logic             tbl_rd,
  input  byte_t            ack_data,
  input  addr_t            pc_in,
  input  addr_t            sp_in,
  input  addr_t            tbl_data,
  input  byte_t            i_reg,
  input  logic [1:0]       im_mode,
  input  logic             in_rst,
  input  logic             in_nmi,
  output addr_t            tbl_addr,
  output logic             short_end,
  output addr_t            resp_target,
  output logic             resp_push,
  output logic [CYC_W-1:0] resp_cycles,
  output addr_t            ret_addr,
  output addr_t            push_addr_hi,
  output addr_t            push_addr_lo
);

  localparam int ACK_CLKS = SETTLE_CLKS + 4;

  byte_t ack_q;
  addr_t ret_q;
  addr_t sp_q;
  addr_t tbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= '0;
      ret_q <= '0;
      sp_q  <= '0;
      tbl_q <= '0;
    end else begin
      if (take) begin
        ret_q <= pc_in;
        sp_q  <= sp_in;
      end
      if (sample_en) ack_q <= ack_data;
      if (tbl_rd)    tbl_q <= tbl_data;
    end
  end

  assign tbl_addr     = table_ptr(i_reg, ack_q);
  assign short_end    = (im_mode == MODE_BUS_OP) && !is_restart(ack_q);
  assign ret_addr     = ret_q;
  assign push_addr_hi = stack_slot(sp_q, 1);
  assign push_addr_lo = stack_slot(sp_q, 2);

  always_comb begin
    resp_target = '0;
    resp_push   = 1'b0;
    resp_cycles = CYC_W'(RST_CLKS);
    if (in_rst) begin
      resp_target = '0;
      resp_push   = 1'b0;
      resp_cycles = CYC_W'(RST_CLKS);
    end else if (in_nmi) begin
      resp_target = NMI_VECTOR;
      resp_push   = 1'b1;
      resp_cycles = CYC_W'(NMI_CLKS);
    end else begin
      case (im_mode)
        MODE_FIXED: begin
          resp_target = FIX_VECTOR;
          resp_push   = 1'b1;
          resp_cycles = CYC_W'(INT_CLKS);
        end
        MODE_TABLE: begin
          resp_target = tbl_q;
          resp_push   = 1'b1;
          resp_cycles = CYC_W'(INT_CLKS);
        end
        default: begin
          if (is_restart(ack_q)) begin
            resp_target = restart_target(ack_q);
            resp_push   = 1'b1;
            resp_cycles = CYC_W'(INT_CLKS);
          end else begin
            resp_target = ret_q;
            resp_push   = 1'b0;
            resp_cycles = CYC_W'(ACK_CLKS);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/irq_resp_ctrl.sv
module irq_resp_ctrl
  import irq_resp_pkg::*;
#(
  parameter int          SETTLE_CLKS = 2,
  parameter int          NMI_M1_CLKS = 4,
  parameter int          RST_CLKS    = 3,
  parameter int          NMI_CLKS    = 11,
  parameter int          INT_CLKS    = 13,
  parameter logic [15:0] NMI_VECTOR  = 16'h0066,
  parameter logic [15:0] FIX_VECTOR  = 16'h0038
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_boundary,
  input  logic        nmi_req,
  input  logic        int_req,
  input  logic [7:0]  ack_data,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  input  logic        cmd_ei,
  input  logic        cmd_di,
  input  logic        cmd_retn,
  input  logic        cmd_im,
  input  logic [1:0]  im_sel,
  input  logic        cmd_ld_i,
  input  logic [7:0]  i_data,
  input  logic [15:0] tbl_data,
  output logic        m1_n,
  output logic        iorq_n,
  output logic        rfsh_n,
  output logic        tbl_rd,
  output logic [15:0] tbl_addr,
  output logic        resp_valid,
  output logic [1:0]  resp_kind,
  output logic [15:0] resp_target,
  output logic        resp_push,
  output logic [3:0]  resp_cycles,
  output logic [15:0] ret_addr,
  output logic [15:0] push_addr_hi,
  output logic [15:0] push_addr_lo,
  output logic        halt_release,
  output logic        iff1,
  output logic        iff2,
  output logic [1:0]  im_mode,
  output logic [7:0]  i_reg
);

  localparam int CNT_W = $clog2(INT_CLKS + 1);
  localparam int CYC_W = 4;

  logic idle, take_nmi, take_int;
  logic in_rst, in_nmi, in_int;
  logic sample_en, short_end;

  irq_flag_regs u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle     (idle),
    .take_nmi (take_nmi),
    .take_int (take_int),
    .cmd_ei   (cmd_ei),
    .cmd_di   (cmd_di),
    .cmd_retn (cmd_retn),
    .cmd_im   (cmd_im),
    .im_sel   (im_sel),
    .cmd_ld_i (cmd_ld_i),
    .i_data   (i_data),
    .iff1     (iff1),
    .iff2     (iff2),
    .im_mode  (im_mode),
    .i_reg    (i_reg)
  );

  irq_sequencer #(
    .SETTLE_CLKS (SETTLE_CLKS),
    .NMI_M1_CLKS (NMI_M1_CLKS),
    .RST_CLKS    (RST_CLKS),
    .NMI_CLKS    (NMI_CLKS),
    .INT_CLKS    (INT_CLKS),
    .CNT_W       (CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_boundary (insn_boundary),
    .nmi_req       (nmi_req),
    .int_req       (int_req),
    .iff1          (iff1),
    .im_mode       (im_mode),
    .short_end     (short_end),
    .idle          (idle),
    .take_nmi      (take_nmi),
    .take_int      (take_int),
    .in_rst        (in_rst),
    .in_nmi        (in_nmi),
    .in_int        (in_int),
    .sample_en     (sample_en),
    .tbl_rd        (tbl_rd),
    .m1_n          (m1_n),
    .iorq_n        (iorq_n),
    .rfsh_n        (rfsh_n),
    .resp_valid    (resp_valid)
  );

  irq_vector_unit #(
    .SETTLE_CLKS (SETTLE_CLKS),
    .RST_CLKS    (RST_CLKS),
    .NMI_CLKS    (NMI_CLKS),
    .INT_CLKS    (INT_CLKS),
    .CYC_W       (CYC_W),
    .NMI_VECTOR  (NMI_VECTOR),
    .FIX_VECTOR  (FIX_VECTOR)
  ) u_vec (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take_nmi | take_int),
    .sample_en    (sample_en),
    .tbl_rd       (tbl_rd),
    .ack_data     (ack_data),
    .pc_in        (pc_in),
    .sp_in        (sp_in),
    .tbl_data     (tbl_data),
    .i_reg        (i_reg),
    .im_mode      (im_mode),
    .in_rst       (in_rst),
    .in_nmi       (in_nmi),
    .tbl_addr     (tbl_addr),
    .short_end    (short_end),
    .resp_target  (resp_target),
    .resp_push    (resp_push),
    .resp_cycles  (resp_cycles),
    .ret_addr     (ret_addr),
    .push_addr_hi (push_addr_hi),
    .push_addr_lo (push_addr_lo)
  );

  assign resp_kind    = in_rst ? KIND_RESET : (in_nmi ? KIND_NMI : KIND_INT);
  assign halt_release = resp_valid & ~in_rst;

endmodule

// File: rtl/irq_resp_ctrl_chk.sv
module irq_resp_ctrl_chk #(
  parameter logic [15:0] NMI_VECTOR = 16'h0066
)(
  input logic        clk,
  input logic        rst_n,
  input logic        m1_n,
  input logic        iorq_n,
  input logic        rfsh_n,
  input logic        tbl_rd,
  input logic        resp_valid,
  input logic [1:0]  resp_kind,
  input logic [15:0] resp_target,
  input logic        resp_push,
  input logic [15:0] push_addr_hi,
  input logic [15:0] push_addr_lo,
  input logic        iff1,
  input logic        iff2,
  input logic        idle,
  input logic        take_nmi,
  input logic        take_int,
  input logic        cmd_ei,
  input logic        cmd_di,
  input logic        cmd_retn
);

  assert_iorq_inside_m1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !iorq_n |-> !m1_n);

  assert_refresh_after_iorq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_n |-> $past(!iorq_n));

  assert_int_clears_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_int |=> (!iff1 && !iff2));

  assert_nmi_copies_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> (!iff1 && (iff2 == $past(iff1))));

  assert_nmi_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_kind == 2'd1) |-> (resp_target == NMI_VECTOR && resp_push));

  assert_retn_restores_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_retn && !cmd_ei && !cmd_di && !take_nmi && !take_int) |=> (iff1 == $past(iff2)));

  assert_stack_slots_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_push) |-> (push_addr_hi == push_addr_lo + 16'd1));

  assert_single_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_table_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd |-> (m1_n && iorq_n && $past(!rfsh_n)));

endmodule

bind irq_resp_ctrl irq_resp_ctrl_chk #(.NMI_VECTOR(NMI_VECTOR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .m1_n         (m1_n),
  .iorq_n       (iorq_n),
  .rfsh_n       (rfsh_n),
  .tbl_rd       (tbl_rd),
  .resp_valid   (resp_valid),
  .resp_kind    (resp_kind),
  .resp_target  (resp_target),
  .resp_push    (resp_push),
  .push_addr_hi (push_addr_hi),
  .push_addr_lo (push_addr_lo),
  .iff1         (iff1),
  .iff2         (iff2),
  .idle         (idle),
  .take_nmi     (take_nmi),
  .take_int     (take_int),
  .cmd_ei       (cmd_ei),
  .cmd_di       (cmd_di),
  .cmd_retn     (cmd_retn)
);

// File: tb/irq_resp_ctrl_test.sv
module irq_resp_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_boundary = 1'b0, nmi_req = 1'b0, int_req = 1'b0;
  logic [7:0]  ack_data = 8'h00;
  logic [15:0] pc_in = 16'h0000, sp_in = 16'h0000;
  logic        cmd_ei = 1'b0, cmd_di = 1'b0, cmd_retn = 1'b0, cmd_im = 1'b0, cmd_ld_i = 1'b0;
  logic [1:0]  im_sel = 2'd0;
  logic [7:0]  i_data = 8'h00;
  logic [15:0] tbl_data;
  logic        m1_n, iorq_n, rfsh_n, tbl_rd, resp_valid, resp_push, halt_release;
  logic        iff1, iff2;
  logic [15:0] tbl_addr, resp_target, ret_addr, push_addr_hi, push_addr_lo;
  logic [1:0]  resp_kind, im_mode;
  logic [3:0]  resp_cycles;
  logic [7:0]  i_reg;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic       m_iff1 = 1'b0, m_iff2 = 1'b0;
  logic [1:0] m_im = 2'd0;
  logic [7:0] m_i = 8'h00;

  always #4 clk = ~clk;

  function automatic logic [15:0] table_word(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  assign tbl_data = table_word(tbl_addr);

  irq_resp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .nmi_req(nmi_req),
    .int_req(int_req), .ack_data(ack_data), .pc_in(pc_in), .sp_in(sp_in),
    .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_retn(cmd_retn), .cmd_im(cmd_im),
    .im_sel(im_sel), .cmd_ld_i(cmd_ld_i), .i_data(i_data), .tbl_data(tbl_data),
    .m1_n(m1_n), .iorq_n(iorq_n), .rfsh_n(rfsh_n), .tbl_rd(tbl_rd), .tbl_addr(tbl_addr),
    .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_target(resp_target),
    .resp_push(resp_push), .resp_cycles(resp_cycles), .ret_addr(ret_addr),
    .push_addr_hi(push_addr_hi), .push_addr_lo(push_addr_lo), .halt_release(halt_release),
    .iff1(iff1), .iff2(iff2), .im_mode(im_mode), .i_reg(i_reg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    check(req, {iff1, iff2}, {m_iff1, m_iff2});
    check(req, {im_mode, i_reg}, {m_im, m_i});
  endtask

  // one-clock command pulse driven between edges
  task automatic pulse_cmd(input int which, input logic [7:0] val);
    @(negedge clk);
    case (which)
      0: cmd_ei = 1'b1;
      1: cmd_di = 1'b1;
      2: cmd_retn = 1'b1;
      3: begin cmd_im = 1'b1; im_sel = val[1:0]; end
      default: begin cmd_ld_i = 1'b1; i_data = val; end
    endcase
    @(negedge clk);
    cmd_ei = 1'b0; cmd_di = 1'b0; cmd_retn = 1'b0; cmd_im = 1'b0; cmd_ld_i = 1'b0;
    case (which)
      0: begin m_iff1 = 1'b1; m_iff2 = 1'b1; end
      1: begin m_iff1 = 1'b0; m_iff2 = 1'b0; end
      2: m_iff1 = m_iff2;
      3: if (val[1:0] != 2'd3) m_im = val[1:0];
      default: m_i = val;
    endcase
  endtask

  // maskable request accepted at one boundary; observes clocks 0..14
  task automatic run_int(input logic [7:0] b, input logic [15:0] pc, input logic [15:0] sp,
                         input logic ei_same, input string tag);
    int resp_at = -1;
    int pin_bad = 0;
    logic [15:0] got_t = 16'h0, got_ret = 16'h0, got_hi = 16'h0, got_lo = 16'h0;
    logic [15:0] exp_t;
    logic [15:0] seen_tbl_addr = 16'hFFFF;
    logic [1:0]  got_k = 2'd3;
    logic [3:0]  got_c = 4'h0;
    logic        got_p = 1'b0, got_h = 1'b0;
    logic        exp_p;
    int          exp_at, exp_c;
    logic        rst_op;
    @(negedge clk);
    insn_boundary = 1'b1; int_req = 1'b1; ack_data = b; pc_in = pc; sp_in = sp; cmd_ei = ei_same;
    for (int n = 0; n < 15; n++) begin
      @(negedge clk);
      if (n == 0) begin insn_boundary = 1'b0; int_req = 1'b0; cmd_ei = 1'b0; end
      if (m1_n !== !(n >= 2 && n <= 5)) pin_bad++;
      if (iorq_n !== !(n == 4)) pin_bad++;
      if (rfsh_n !== !(n == 5)) pin_bad++;
      if (tbl_rd !== (m_im == 2'd2 && n == 6)) pin_bad++;
      if (tbl_rd) seen_tbl_addr = tbl_addr;
      if (resp_valid && resp_at < 0) begin
        resp_at = n; got_t = resp_target; got_p = resp_push; got_c = resp_cycles;
        got_k = resp_kind; got_ret = ret_addr; got_hi = push_addr_hi; got_lo = push_addr_lo;
        got_h = halt_release;
      end
    end
    m_iff1 = 1'b0; m_iff2 = 1'b0;
    rst_op = (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
    exp_p = 1'b1; exp_c = 13; exp_at = 12;
    case (m_im)
      2'd1: exp_t = 16'h0038;
      2'd2: exp_t = table_word({m_i, b});
      default: begin
        if (rst_op) exp_t = {10'd0, b[5:3], 3'd0};
        else begin exp_t = pc; exp_p = 1'b0; exp_c = 6; exp_at = 5; end
      end
    endcase
    check({"R5 pins ", tag}, pin_bad, 0);
    check({tag, " resp clock"}, resp_at, exp_at);
    check({tag, " target"}, got_t, exp_t);
    check({tag, " push/cycles"}, {got_p, got_c}, {exp_p, 4'(exp_c)});
    check("R4 kind", {got_k, got_h}, {2'd2, 1'b1});
    check("R10 return address", got_ret, pc);
    if (exp_p) check("R10 stack slots", {got_hi, got_lo}, {sp - 16'd1, sp - 16'd2});
    if (m_im == 2'd2) check("R7 table address", seen_tbl_addr, {m_i, b});
    check(ei_same ? "R13 enables" : "R4 enables", {iff1, iff2}, 2'b00);
  endtask

  task automatic run_nmi(input logic [15:0] pc, input logic [15:0] sp, input logic with_int,
                         input int gap);
    int resp_at = -1;
    int pin_bad = 0;
    logic [15:0] got_t = 16'h0;
    logic [1:0]  got_k = 2'd3;
    logic [3:0]  got_c = 4'h0;
    logic        got_p = 1'b0, got_h = 1'b0;
    logic        old1;
    @(negedge clk);
    nmi_req = 1'b1;
    @(negedge clk);
    nmi_req = 1'b0;
    repeat (gap) @(negedge clk);
    insn_boundary = 1'b1; int_req = with_int; pc_in = pc; sp_in = sp;
    for (int n = 0; n < 13; n++) begin
      @(negedge clk);
      if (n == 0) begin insn_boundary = 1'b0; int_req = 1'b0; end
      if (m1_n !== !(n < 4)) pin_bad++;
      if (iorq_n !== 1'b1 || rfsh_n !== 1'b1) pin_bad++;
      if (resp_valid && resp_at < 0) begin
        resp_at = n; got_t = resp_target; got_p = resp_push; got_c = resp_cycles;
        got_k = resp_kind; got_h = halt_release;
      end
    end
    old1 = m_iff1;
    m_iff2 = old1; m_iff1 = 1'b0;
    check("R2 pins", pin_bad, 0);
    check("R2 resp clock", resp_at, 10);
    check(with_int ? "R3 priority kind" : "R2 kind", {got_k, got_h}, {2'd1, 1'b1});
    check("R2 target", got_t, 16'h0066);
    check("R2 push/cycles", {got_p, got_c}, {1'b1, 4'd11});
    check("R2 enables", {iff1, iff2}, {m_iff1, m_iff2});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int quiet;
    logic [7:0] rb;
    int unsigned seed_set;
    seed_set = $urandom(32'h5EED_0042);

    // R1: state while held in reset, then the reset response
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_flags("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no early response", resp_valid, 1'b0);
    @(negedge clk);
    check("R1 response valid", resp_valid, 1'b1);
    check("R1 response fields", {resp_kind, resp_target, resp_push, resp_cycles},
          {2'd0, 16'h0000, 1'b0, 4'd3});
    @(negedge clk);
    check("R1 single response", resp_valid, 1'b0);

    // R11: commands
    pulse_cmd(3, 8'd1);
    pulse_cmd(4, 8'h80);
    pulse_cmd(0, 8'h00);
    check_flags("R11 ei/im/ld_i");
    pulse_cmd(3, 8'd3);
    check_flags("R11 code 3 ignored");

    // R4: no boundary -> nothing happens
    quiet = 0;
    @(negedge clk);
    int_req = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (m1_n !== 1'b1 || resp_valid !== 1'b0) quiet++;
    end
    int_req = 1'b0;
    check("R4 no boundary", quiet, 0);
    check_flags("R4 no boundary flags");

    // R4: boundary with first enable clear -> nothing happens
    pulse_cmd(1, 8'h00);
    quiet = 0;
    @(negedge clk);
    insn_boundary = 1'b1; int_req = 1'b1;
    @(negedge clk);
    insn_boundary = 1'b0; int_req = 1'b0;
    repeat (14) begin
      @(negedge clk);
      if (m1_n !== 1'b1 || resp_valid !== 1'b0) quiet++;
    end
    check("R4 disabled", quiet, 0);

    // R6: mode 1, bus byte ignored
    pulse_cmd(0, 8'h00);
    run_int(8'hA5, 16'h1234, 16'h8000, 1'b0, "R6");
    pulse_cmd(0, 8'h00);
    run_int(8'hFF, 16'h0001, 16'h0000, 1'b0, "R6");

    // R7: mode 2 table
    pulse_cmd(3, 8'd2);
    pulse_cmd(4, 8'h3F);
    pulse_cmd(0, 8'h00);
    run_int(8'h10, 16'hBEEF, 16'hFFF0, 1'b0, "R7");

    // R8 / R9: mode 0
    pulse_cmd(3, 8'd0);
    pulse_cmd(0, 8'h00);
    run_int(8'hEF, 16'h4000, 16'h2000, 1'b0, "R8");
    pulse_cmd(0, 8'h00);
    run_int(8'hC7, 16'h4001, 16'h2000, 1'b0, "R8");
    pulse_cmd(0, 8'h00);
    run_int(8'h00, 16'h5555, 16'h2000, 1'b0, "R9");

    // R13: enable in the same clock as acceptance
    pulse_cmd(3, 8'd1);
    pulse_cmd(0, 8'h00);
    run_int(8'h12, 16'h0100, 16'h9000, 1'b1, "R13");
    check_flags("R13 flags");

    // R2 / R12: NMI with enables set, then return from NMI
    pulse_cmd(0, 8'h00);
    run_nmi(16'h7777, 16'hC000, 1'b0, 3);
    pulse_cmd(2, 8'h00);
    check("R12 restore", {iff1, iff2}, 2'b11);

    // R3: NMI and maskable at the same boundary
    run_nmi(16'h2222, 16'hC000, 1'b1, 0);
    pulse_cmd(2, 8'h00);
    check("R12 restore after priority", {iff1, iff2}, {m_iff1, m_iff2});

    // random mix
    for (int k = 0; k < 24; k++) begin
      pulse_cmd(3, 8'($urandom_range(0, 3)));
      pulse_cmd(4, 8'($urandom));
      pulse_cmd(0, 8'h00);
      rb = 8'($urandom);
      if ($urandom_range(0, 1) == 1) rb = {2'b11, rb[5:3], 3'b111};
      run_int(rb, 16'($urandom), 16'($urandom), 1'b0,
              (m_im == 2'd1) ? "R6" : (m_im == 2'd2) ? "R7" : "R8/R9");
      check_flags("R11 random flags");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule